// File: doc/BRIEF.md
# Store Verification Queue with Unverified-Line Tracking

This block pairs a leading thread and a trailing thread that run the same program on one core and share one L1 data cache. A store committed by the leading thread goes into the cache at once, without waiting for any check. The block marks the touched cache line as unverified and keeps the store's address and data in an ordered check queue. When the trailing thread commits the same store, the block compares it with the oldest queued entry. A match sends the checked word down to the next cache level as a write-back. A mismatch is treated as a soft error: the block raises a fault and names every unverified line so the cache can drop them.

The cache asks whether a line may leave the core through a lookup port. A line with its unverified mark set must stay put. It may not be evicted, and it may not be handed to another node. The mark on a line is cleared after a successful check only when no other queued store still targets that line. To decide this, the block searches the queue associatively on each trailing-thread store. Leading-thread loads never search the queue, because they read the up-to-date data straight from the cache.

Top module: `store_verify_queue`

## Requirements
- R1: After reset the queue is empty and no line is held. The leading port is ready, the trailing port is not ready, and `fault` and `wb_valid` are 0.
- R2: A leading store accepted in cycle t (valid and ready high at the same edge) makes `look_pinned` read 1 for its line from cycle t+1 on. Its line is address bits [ADDR_W-1:LINE_OFS].
- R3: The queue holds up to DEPTH entries. While it is full, `mst_ready` is 0 and a leading store offered then is neither queued nor marked.
- R4: While the queue is empty, `slv_ready` is 0. A trailing store offered then produces no write-back and no fault.
- R5: An accepted trailing store is compared with the oldest queued entry on both the full address and the data word. If both are equal, `wb_valid` is 1 for exactly the next cycle, with `wb_addr`/`wb_data` equal to the trailing store.
- R6: After a matching check, the line of the checked entry stops being held in the next cycle, unless another queued entry targets the same line. A store to that line accepted in the same cycle also counts as such an entry.
- R7: Line identity ignores the low LINE_OFS address bits. Two stores to different offsets in one line keep the line held until both have been checked.
- R8: If the address or the data differs, `fault` is 1 for exactly the next cycle and there is no write-back. In that cycle `inv_lines` has bit n set for each line n that was held, plus the line of a leading store accepted in the same cycle.
- R9: The fault cycle finds the queue emptied and every line released. Both ready outputs are 0 during that cycle. The cycle after it, the leading port is ready and the trailing port is not.
- R10: `look_pinned` reports, without a clock delay, the held state of the line given on `look_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mst_valid | input | 1 | Leading-thread store commit offered |
| mst_ready | output | 1 | Leading-thread store can be accepted |
| mst_addr | input | ADDR_W | Leading store address |
| mst_data | input | DATA_W | Leading store data word |
| slv_valid | input | 1 | Trailing-thread store commit offered |
| slv_ready | output | 1 | Trailing-thread store can be checked |
| slv_addr | input | ADDR_W | Trailing store address |
| slv_data | input | DATA_W | Trailing store data word |
| look_line | input | ADDR_W-LINE_OFS | Line number asked about by the cache |
| look_pinned | output | 1 | Line is unverified: no eviction, no sharing |
| wb_valid | output | 1 | Checked word write-back request |
| wb_addr | output | ADDR_W | Write-back address |
| wb_data | output | DATA_W | Write-back data |
| fault | output | 1 | Check mismatch, rollback required |
| inv_lines | output | 2**(ADDR_W-LINE_OFS) | Lines to invalidate, valid with `fault` |

## Verification
A near-exhaustive sweep assigns four queued stores every combination of three lines, at varying offsets. The fourth push lands in the same cycle as the first check. This separates the case where a line must stay held from the case where it may be released, including the tie created by a same-cycle push. A second sweep injects a mismatch at each queue position, once each in a different line's address, in an offset within the same line, and in the data. This shows that comparison covers the full address and the word, and that the invalidation set matches the held lines. Extra runs of filling to capacity and popping an empty queue show that offered stores are refused and leave no trace.

// File: rtl/svq_pkg.sv
`timescale 1ns/1ps
package svq_pkg;

  // True when two addresses fall into the same cache line.
  function automatic logic same_line(input logic [31:0] a, input logic [31:0] b,
                                     input int unsigned ofs);
    return (a >> ofs) == (b >> ofs);
  endfunction

  // Circular pointer advance for a queue of the given depth.
  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/svq_queue.sv
`timescale 1ns/1ps
module svq_queue
  import svq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int LINE_OFS = 6,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              flush,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty,
  output logic              other_hit
);

  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [DEPTH-1:0]  live_q;
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;
  logic [CNT_W-1:0]  cnt_q;

  assign count     = cnt_q;
  assign full      = (cnt_q == CNT_W'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = addr_mem[rd_ptr];
  assign head_data = data_mem[rd_ptr];

  // Associative search: any live entry besides the head in the head's line.
  always_comb begin
    other_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (live_q[i] && (PTR_W'(i) != rd_ptr) &&
          same_line(32'(addr_mem[i]), 32'(head_addr), LINE_OFS))
        other_hit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) begin
      addr_mem[wr_ptr] <= push_addr;
      data_mem[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
      live_q <= '0;
    end else begin
      if (push) begin
        live_q[wr_ptr] <= 1'b1;
        wr_ptr <= PTR_W'(wrap_inc(32'(wr_ptr), DEPTH));
      end
      if (pop) begin
        live_q[rd_ptr] <= 1'b0;
        rd_ptr <= PTR_W'(wrap_inc(32'(rd_ptr), DEPTH));
      end
      cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/svq_flags.sv
`timescale 1ns/1ps
module svq_flags #(
  parameter int LIDX_W = 6,
  localparam int NLINES = 1 << LIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [LIDX_W-1:0] set_line,
  input  logic              clr_en,
  input  logic [LIDX_W-1:0] clr_line,
  input  logic              flush,
  input  logic [LIDX_W-1:0] look_line,
  output logic [NLINES-1:0] uv_vec,
  output logic              look_pinned
);

  logic [NLINES-1:0] uv_q;

  // One unverified mark per line; a set beats a clear in the same cycle.
  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n || flush)
        uv_q[g] <= 1'b0;
      else if (set_en && set_line == LIDX_W'(g))
        uv_q[g] <= 1'b1;
      else if (clr_en && clr_line == LIDX_W'(g))
        uv_q[g] <= 1'b0;
    end
  end

  assign uv_vec      = uv_q;
  assign look_pinned = uv_q[look_line];

endmodule

// File: rtl/svq_verdict.sv
`timescale 1ns/1ps
module svq_verdict #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int NLINES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pop,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [DATA_W-1:0] head_data,
  input  logic [ADDR_W-1:0] slv_addr,
  input  logic [DATA_W-1:0] slv_data,
  input  logic [NLINES-1:0] held_vec,
  input  logic [NLINES-1:0] set_vec,
  output logic              chk_match,
  output logic              chk_miss,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              fault,
  output logic [NLINES-1:0] inv_lines
);

  logic same;
  assign same      = (head_addr == slv_addr) && (head_data == slv_data);
  assign chk_match = pop && same;
  assign chk_miss  = pop && !same;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid  <= 1'b0;
      wb_addr   <= '0;
      wb_data   <= '0;
      fault     <= 1'b0;
      inv_lines <= '0;
    end else begin
      wb_valid <= chk_match;
      if (chk_match) begin
        wb_addr <= slv_addr;
        wb_data <= slv_data;
      end
      fault     <= chk_miss;
      inv_lines <= chk_miss ? (held_vec | set_vec) : '0;
    end
  end

endmodule

// File: rtl/store_verify_queue.sv
`timescale 1ns/1ps
module store_verify_queue
  import svq_pkg::*;
#(
  parameter int DEPTH    = 64,
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int LINE_OFS = 6
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              mst_valid,
  output logic                              mst_ready,
  input  logic [ADDR_W-1:0]                 mst_addr,
  input  logic [DATA_W-1:0]                 mst_data,
  input  logic                              slv_valid,
  output logic                              slv_ready,
  input  logic [ADDR_W-1:0]                 slv_addr,
  input  logic [DATA_W-1:0]                 slv_data,
  input  logic [ADDR_W-LINE_OFS-1:0]        look_line,
  output logic                              look_pinned,
  output logic                              wb_valid,
  output logic [ADDR_W-1:0]                 wb_addr,
  output logic [DATA_W-1:0]                 wb_data,
  output logic                              fault,
  output logic [(1<<(ADDR_W-LINE_OFS))-1:0] inv_lines
);

  localparam int LIDX_W = ADDR_W - LINE_OFS;
  localparam int NLINES = 1 << LIDX_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  // Named internal events.
  logic              push_fire, pop_fire, chk_match, chk_miss, line_clear;
  logic              q_full, q_empty, srch_hit, push_same_line;
  logic [CNT_W-1:0]  q_count;
  logic [ADDR_W-1:0] head_addr;
  logic [DATA_W-1:0] head_data;
  logic [NLINES-1:0] uv_vec, set_vec;
  logic [LIDX_W-1:0] set_line, head_line;

  assign mst_ready = !fault && !q_full;
  assign slv_ready = !fault && !q_empty;
  assign push_fire = mst_valid && mst_ready;
  assign pop_fire  = slv_valid && slv_ready;
  assign set_line  = mst_addr[ADDR_W-1:LINE_OFS];
  assign head_line = head_addr[ADDR_W-1:LINE_OFS];

  always_comb begin
    set_vec = '0;
    if (push_fire) set_vec[set_line] = 1'b1;
  end

  assign push_same_line = push_fire && same_line(32'(mst_addr), 32'(head_addr), LINE_OFS);
  assign line_clear     = chk_match && !srch_hit && !push_same_line;

  svq_queue #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_OFS(LINE_OFS)
  ) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(push_fire), .push_addr(mst_addr), .push_data(mst_data),
    .pop(pop_fire), .flush(chk_miss),
    .head_addr(head_addr), .head_data(head_data),
    .count(q_count), .full(q_full), .empty(q_empty),
    .other_hit(srch_hit)
  );

  svq_flags #(.LIDX_W(LIDX_W)) u_flags (
    .clk(clk), .rst_n(rst_n),
    .set_en(push_fire), .set_line(set_line),
    .clr_en(line_clear), .clr_line(head_line),
    .flush(chk_miss),
    .look_line(look_line),
    .uv_vec(uv_vec), .look_pinned(look_pinned)
  );

  svq_verdict #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NLINES(NLINES)) u_verdict (
    .clk(clk), .rst_n(rst_n),
    .pop(pop_fire), .head_addr(head_addr), .head_data(head_data),
    .slv_addr(slv_addr), .slv_data(slv_data),
    .held_vec(uv_vec), .set_vec(set_vec),
    .chk_match(chk_match), .chk_miss(chk_miss),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .fault(fault), .inv_lines(inv_lines)
  );

endmodule

// File: rtl/svq_checker.sv
`timescale 1ns/1ps
module svq_checker #(
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 7,
  parameter int NLINES = 64,
  parameter int LIDX_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              push_fire,
  input logic              pop_fire,
  input logic              chk_match,
  input logic              chk_miss,
  input logic [CNT_W-1:0]  q_count,
  input logic [NLINES-1:0] uv_vec,
  input logic [LIDX_W-1:0] set_line,
  input logic              mst_ready,
  input logic              slv_ready,
  input logic              wb_valid,
  input logic              fault
);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> (q_count < CNT_W'(DEPTH)));

  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_fire |-> (q_count != '0));

  assert_mark_after_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push_fire && !chk_miss) |=> uv_vec[$past(set_line)]);

  assert_wb_after_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_match |=> wb_valid);

  assert_fault_after_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chk_miss |=> (fault && !wb_valid));

  assert_fault_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  assert_fault_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (uv_vec == '0 && q_count == '0 && !mst_ready && !slv_ready));

endmodule

bind store_verify_queue svq_checker #(
  .DEPTH(DEPTH), .CNT_W(CNT_W), .NLINES(NLINES), .LIDX_W(LIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .push_fire(push_fire), .pop_fire(pop_fire),
  .chk_match(chk_match), .chk_miss(chk_miss),
  .q_count(q_count), .uv_vec(uv_vec), .set_line(set_line),
  .mst_ready(mst_ready), .slv_ready(slv_ready),
  .wb_valid(wb_valid), .fault(fault)
);

// File: tb/sim_store_verify_queue.sv
`timescale 1ns/1ps
module sim_store_verify_queue;

  localparam int DEPTH = 4;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int OFS   = 6;
  localparam int NL    = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mst_valid = 1'b0, slv_valid = 1'b0;
  logic [AW-1:0] mst_addr = '0, slv_addr = '0;
  logic [DW-1:0] mst_data = '0, slv_data = '0;
  logic [3:0]    look_line = '0;
  logic          mst_ready, slv_ready, look_pinned, wb_valid, fault;
  logic [AW-1:0] wb_addr;
  logic [DW-1:0] wb_data;
  logic [NL-1:0] inv_lines;

  always #5 clk = ~clk;

  store_verify_queue #(.DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .LINE_OFS(OFS)) u0 (
    .clk(clk), .rst_n(rst_n),
    .mst_valid(mst_valid), .mst_ready(mst_ready), .mst_addr(mst_addr), .mst_data(mst_data),
    .slv_valid(slv_valid), .slv_ready(slv_ready), .slv_addr(slv_addr), .slv_data(slv_data),
    .look_line(look_line), .look_pinned(look_pinned),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .fault(fault), .inv_lines(inv_lines)
  );

  int total = 0, failed = 0;

  // Bench-side expectation state, built from the requirements.
  logic [AW-1:0] qa[$];
  logic [DW-1:0] qd[$];
  logic [NL-1:0] held = '0;
  bit            in_fault = 0;

  task automatic check(input bit ok, input string msg, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic sweep_holds(input string msg);
    logic [NL-1:0] got;
    for (int l = 0; l < NL; l++) begin
      look_line = 4'(l);
      #0.2;
      got[l] = look_pinned;
    end
    check(got === held, msg, got, held);
  endtask

  function automatic logic [3:0] ln(input logic [AW-1:0] a);
    return a[AW-1:OFS];
  endfunction

  function automatic logic [AW-1:0] mk(input int line, input int off);
    return {4'(line), 6'(off)};
  endfunction

  task automatic step(input logic mv, input logic [AW-1:0] ma, input logic [DW-1:0] md,
                      input logic sv, input logic [AW-1:0] sa, input logic [DW-1:0] sd);
    bit em, es, push, pop, miss, ewb, other;
    logic [NL-1:0] einv;
    logic [AW-1:0] ha;
    logic [DW-1:0] hd;
    @(negedge clk);
    mst_valid = mv; mst_addr = ma; mst_data = md;
    slv_valid = sv; slv_addr = sa; slv_data = sd;
    #1;
    em = !in_fault && (qa.size() < DEPTH);
    es = !in_fault && (qa.size() > 0);
    check(mst_ready === em, in_fault ? "R9 leading ready in fault" : "R3 leading ready", mst_ready, em);
    check(slv_ready === es, in_fault ? "R9 trailing ready in fault" : "R4 trailing ready", slv_ready, es);
    push = mv && em;
    pop  = sv && es;
    miss = 0; ewb = 0; einv = '0; ha = '0; hd = '0;
    if (pop) begin
      ha = qa[0]; hd = qd[0];
      miss = (ha != sa) || (hd != sd);
    end
    if (miss) begin
      einv = held;
      if (push) einv[ln(ma)] = 1'b1;
      qa.delete(); qd.delete();
      held = '0;
    end else begin
      if (pop) begin
        void'(qa.pop_front()); void'(qd.pop_front());
        ewb = 1;
      end
      if (push) begin
        qa.push_back(ma); qd.push_back(md);
        held[ln(ma)] = 1'b1;
      end
      if (pop) begin
        other = 0;
        foreach (qa[i]) if (ln(qa[i]) == ln(ha)) other = 1;
        if (!other) held[ln(ha)] = 1'b0;
      end
    end
    @(posedge clk);
    #1;
    check(fault === miss, "R8 fault pulse", fault, miss);
    check(wb_valid === ewb, "R5 write-back valid", wb_valid, ewb);
    if (ewb) begin
      check(wb_addr === sa, "R5 write-back address", wb_addr, sa);
      check(wb_data === sd, "R5 write-back data", wb_data, sd);
    end
    check(inv_lines === einv, "R8 invalidation set", inv_lines, einv);
    sweep_holds("R2 R6 R7 R10 held lines");
    in_fault = miss;
  endtask

  task automatic mpush(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1, a, d, 0, '0, '0);
  endtask

  task automatic spop(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(0, '0, '0, 1, a, d);
  endtask

  task automatic idle();
    step(0, '0, '0, 0, '0, '0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(mst_ready === 1'b1, "R1 leading ready after reset", mst_ready, 1);
    check(slv_ready === 1'b0, "R1 trailing ready after reset", slv_ready, 0);
    check(fault === 1'b0, "R1 fault after reset", fault, 0);
    check(wb_valid === 1'b0, "R1 write-back after reset", wb_valid, 0);
    sweep_holds("R1 no held line after reset");

    // R4: pop on empty queue is refused
    spop(mk(2, 0), 8'h11);

    // R3: fill to capacity, refused fifth store, drain in order
    for (int k = 0; k < DEPTH; k++) mpush(mk(k + 4, k), 8'(8'h40 + k));
    mpush(mk(12, 3), 8'hEE);
    check(mst_ready === 1'b0, "R3 leading ready while full", mst_ready, 0);
    for (int k = 0; k < DEPTH; k++) spop(mk(k + 4, k), 8'(8'h40 + k));
    check(slv_ready === 1'b0, "R3 refused store left no entry", slv_ready, 0);
    sweep_holds("R3 refused store left no mark");

    // R6 R7: every 3-line assignment of four stores, last push with first check
    for (int p = 0; p < 81; p++) begin
      int lines[4];
      logic [AW-1:0] a[4];
      logic [DW-1:0] d[4];
      int v;
      v = p;
      for (int k = 0; k < 4; k++) begin
        lines[k] = (v % 3) + 1;
        v = v / 3;
        a[k] = mk(lines[k], (k * 8 + p) % 64);
        d[k] = 8'(p * 4 + k);
      end
      for (int k = 0; k < 3; k++) mpush(a[k], d[k]);
      step(1, a[3], d[3], 1, a[0], d[0]);
      for (int k = 1; k < 4; k++) spop(a[k], d[k]);
    end

    // R8 R9: mismatch at each position, in other-line address, same-line offset, data
    for (int pos = 0; pos < 3; pos++) begin
      for (int kind = 0; kind < 3; kind++) begin
        logic [AW-1:0] a[3];
        logic [AW-1:0] bad_a;
        logic [DW-1:0] bad_d;
        a[0] = mk(1, 4); a[1] = mk(2, 8); a[2] = mk(2, 12);
        for (int k = 0; k < 3; k++) mpush(a[k], 8'(8'h70 + k));
        for (int k = 0; k < pos; k++) spop(a[k], 8'(8'h70 + k));
        bad_a = a[pos];
        bad_d = 8'(8'h70 + pos);
        if (kind == 0) bad_a = mk(9, 4);
        else if (kind == 1) bad_a = a[pos] ^ 10'h001;
        else bad_d = bad_d ^ 8'h80;
        step(kind == 0, mk(5, 0), 8'h55, 1, bad_a, bad_d);
        idle();
        check(mst_ready === 1'b1, "R9 leading ready after fault", mst_ready, 1);
        check(slv_ready === 1'b0, "R9 queue empty after fault", slv_ready, 0);
      end
    end

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    #2000000;
    total++;
    failed++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule